// File: doc/BRIEF.md
# SIMD widening unsigned multiply-accumulate

This unit is a vector datapath stage. It takes two 128-bit source operands and a 128-bit accumulator. A half-select bit chooses either the low or the high 64 bits of both sources. The unit cuts that 64-bit slice into unsigned elements of 8, 16 or 32 bits. Each pair of matching elements is multiplied, and the double-width product is added into the matching double-width lane of the accumulator. The result is a full 128-bit vector.

The operation runs in a two-stage pipeline with a fixed latency. A new operation can be accepted on every clock. The time an operation takes never depends on the operand values. A reserved element-size code gives no arithmetic result: the unit raises a flag and drives a zero vector. Register-file access, instruction decode and signed forms are left to the surrounding datapath.

Top module: `widen_mac`

## Requirements
- R1: `size_code` selects the element width: 2'b00 gives 8-bit elements in 8 lanes, 2'b01 gives 16-bit elements in 4 lanes, and 2'b10 gives 32-bit elements in 2 lanes. Element e sits in bits [e*W +: W] of the selected 64-bit slice.
- R2: When `hi_sel` is 0, elements come from bits 63:0 of both `src_a` and `src_b`. When `hi_sel` is 1, they come from bits 127:64 of both. The other half has no effect on the result.
- R3: Both elements are unsigned. Each product is kept at exactly twice the element width.
- R4: Result lane e occupies bits [e*2W +: 2W]. It equals accumulator lane e plus the product of element e of `src_a` and element e of `src_b`, modulo 2^(2W). No carry crosses into the next lane, and there is no saturation.
- R5: With `size_code` 2'b11, the output appears with `out_valid` high, `out_rsvd` high and `result` all zeros.
- R6: `out_valid` rises exactly two clock edges after the edge that samples `in_valid` high. Back-to-back operations give back-to-back results in order.
- R7: After reset, and on every cycle where `out_valid` is low, `out_valid`, `out_rsvd` and `result` are all zero.
- R8: For size codes 2'b00, 2'b01 and 2'b10, `out_rsvd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| size_code | input | 2 | Element width code |
| hi_sel | input | 1 | 0 selects the low 64-bit half, 1 selects the high half |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector |
| acc_in | input | 128 | Accumulator vector of double-width lanes |
| out_valid | output | 1 | Result present |
| out_rsvd | output | 1 | Operation used the reserved size code |
| result | output | 128 | Accumulated double-width lanes |

## Verification
The in-module assertions check the timing on every cycle:
- the fixed two-cycle latency of `out_valid` (R6);
- the zeroed, flag-low outputs while idle (R7);
- the reserved-code outcome, with the flag raised and the result zeroed (R5);
- a low flag for legal codes (R8).

The lane arithmetic can only be shown by the bench's scenarios, which compare against a reference model:
- the mapping from element width to lane (R1);
- the choice of half (R2);
- the unsigned widening (R3);
- lane-contained wraparound (R4).

The bench covers table vectors, random operands for every size and both halves, all-ones operands that force the wrap, and a back-to-back stream.

// File: rtl/widen_mac.sv
`timescale 1ns/1ps
module widen_mac #(
  parameter int HALF_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          size_code,
  input  logic                hi_sel,
  input  logic [2*HALF_W-1:0] src_a,
  input  logic [2*HALF_W-1:0] src_b,
  input  logic [2*HALF_W-1:0] acc_in,
  output logic                out_valid,
  output logic                out_rsvd,
  output logic [2*HALF_W-1:0] result
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [1:0] RSVD = 2'b11;

  logic              s1_v;
  logic [1:0]        s1_sz;
  logic [HALF_W-1:0] s1_a, s1_b;
  logic [FULL_W-1:0] s1_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_sz  <= '0;
      s1_a   <= '0;
      s1_b   <= '0;
      s1_acc <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_sz  <= size_code;
        s1_a   <= hi_sel ? src_a[FULL_W-1:HALF_W] : src_a[HALF_W-1:0];
        s1_b   <= hi_sel ? src_b[FULL_W-1:HALF_W] : src_b[HALF_W-1:0];
        s1_acc <= acc_in;
      end
    end
  end

  wire [FULL_W-1:0] cand [0:2];

  for (genvar g = 0; g < 3; g++) begin : g_size
    localparam int EW = 8 << g;
    localparam int NL = HALF_W / EW;
    for (genvar e = 0; e < NL; e++) begin : g_lane
      assign cand[g][2*EW*e +: 2*EW] = s1_acc[2*EW*e +: 2*EW]
          + (2*EW)'(s1_a[EW*e +: EW]) * (2*EW)'(s1_b[EW*e +: EW]);
    end
  end

  logic [FULL_W-1:0] pick;
  always_comb begin
    case (s1_sz)
      2'b00:   pick = cand[0];
      2'b01:   pick = cand[1];
      2'b10:   pick = cand[2];
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rsvd  <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_v;
      out_rsvd  <= s1_v && (s1_sz == RSVD);
      result    <= s1_v ? pick : '0;
    end
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_no_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result == '0 && !out_rsvd));
  assert_rsvd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == RSVD) |-> ##2 (out_rsvd && out_valid && result == '0));
  assert_legal_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code != RSVD) |-> ##2 !out_rsvd);
endmodule

// File: tb/test_widen_mac.sv
`timescale 1ns/1ps
module test_widen_mac;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   size_code = '0;
  logic         hi_sel = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic         out_valid, out_rsvd;
  logic [127:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  widen_mac i_widen_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .hi_sel(hi_sel), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_rsvd(out_rsvd), .result(result)
  );

  typedef struct packed {
    logic [1:0]   sz;
    logic         hi;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] acc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{2'b00, 1'b0, 128'h0, 128'h0807060504030201_0807060504030201, 128'h0},
    '{2'b00, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF_0102030405060708, 128'h0000_0000_0000_0000_1010101010101010, 128'h0001_0002_0003_0004_0005_0006_0007_0008},
    '{2'b00, 1'b1, 128'h80FF7F01_02030405_AAAAAAAA_AAAAAAAA, 128'h02FF0280_10203040_55555555_55555555, 128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444},
    '{2'b01, 1'b0, 128'hDEADBEEF_DEADBEEF_FFFF8000_00010002, 128'h0_0000_0000_FFFF0002_FFFF0003, 128'hFFFF0000_00000001_00000000_80000000},
    '{2'b01, 1'b1, 128'h1234ABCD_0000FFFF_0_0, 128'h00100020_FFFF0001_9_9, 128'h0000FFFF_FFFF0000_00000000_FFFFFFFF},
    '{2'b10, 1'b1, 128'hFFFFFFFF_80000000_00000001_00000002, 128'hFFFFFFFF_00000002_00000003_00000004, 128'hFFFFFFFFFFFFFFFF_0000000000000001}
  };

  function automatic logic [127:0] ref_mac(input logic [1:0] sz, input logic hi,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc);
    logic [127:0] r = '0;
    int w = 8 << sz;
    int lanes = 64 / w;
    logic [63:0] ha = hi ? a[127:64] : a[63:0];
    logic [63:0] hb = hi ? b[127:64] : b[63:0];
    logic [127:0] emask = (128'd1 << w) - 1;
    logic [127:0] lmask = (w == 64) ? {128{1'b1}} : ((128'd1 << (2*w)) - 1);
    if (sz == 2'b11) return '0;
    for (int e = 0; e < lanes; e++) begin
      logic [127:0] ea = (128'(ha) >> (e*w)) & emask;
      logic [127:0] eb = (128'(hb) >> (e*w)) & emask;
      logic [127:0] la = (acc >> (e*2*w)) & lmask;
      logic [127:0] s = (la + ea * eb) & lmask;
      r = r | (s << (e*2*w));
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic hi, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] acc);
    in_valid = 1'b1; size_code = sz; hi_sel = hi; src_a = a; src_b = b; acc_in = acc;
  endtask

  task automatic one_op(input string req, input logic [1:0] sz, input logic hi,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc);
    @(negedge clk); drive(sz, hi, a, b, acc);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 128'(out_valid), 128'd1);
    chk({req, " rsvd"}, 128'(out_rsvd), 128'(sz == 2'b11));
    chk({req, " result"}, result, ref_mac(sz, hi, a, b, acc));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset valid", 128'(out_valid), 128'd0);
    chk("R7 reset rsvd", 128'(out_rsvd), 128'd0);
    chk("R7 reset result", result, 128'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      one_op("R1 R2 R3 R4 R8 table", VT[i].sz, VT[i].hi, VT[i].a, VT[i].b, VT[i].acc);

    // R2: the unselected half must not change the result
    one_op("R2 low half", 2'b00, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0302010003020100},
           {64'hFFFF_FFFF_FFFF_FFFF, 64'h0101010101010101}, 128'h0);
    chk("R2 ignore high", result, 128'h0003_0002_0001_0000_0003_0002_0001_0000);

    // R4: all-ones wraps inside each lane to 2^(2w) - 2^(w+1)
    one_op("R4 ones8", 2'b00, 1'b0, '1, '1, '1);
    chk("R4 wrap8", result, {8{16'hFE00}});
    one_op("R4 ones16", 2'b01, 1'b1, '1, '1, '1);
    chk("R4 wrap16", result, {4{32'hFFFE_0000}});
    one_op("R4 ones32", 2'b10, 1'b0, '1, '1, '1);
    chk("R4 wrap32", result, {2{64'hFFFF_FFFE_0000_0000}});

    one_op("R5 reserved", 2'b11, 1'b1, '1, '1, '1);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] sz = 2'(i % 3);
      one_op("R1 R2 R3 R4 random", sz, 1'(i / 3), {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
    end

    // R6: back-to-back stream, exact two-cycle latency
    begin
      logic [127:0] x0 = {4{32'h1357_9BDF}};
      logic [127:0] x1 = {4{32'hF0E1_D2C3}};
      @(negedge clk); drive(2'b00, 1'b0, x0, x1, x1);
      @(negedge clk);
      chk("R6 not yet valid", 128'(out_valid), 128'd0);
      drive(2'b01, 1'b1, x1, x0, x0);
      @(negedge clk);
      chk("R6 stream0", result, ref_mac(2'b00, 1'b0, x0, x1, x1));
      drive(2'b11, 1'b0, x0, x0, x0);
      @(negedge clk); in_valid = 1'b0;
      chk("R6 stream1", result, ref_mac(2'b01, 1'b1, x1, x0, x0));
      chk("R6 stream1 valid", 128'(out_valid), 128'd1);
      @(negedge clk);
      chk("R5 stream2 rsvd", 128'(out_rsvd), 128'd1);
      chk("R5 stream2 zero", result, 128'd0);
      @(negedge clk);
      chk("R6 R7 idle valid", 128'(out_valid), 128'd0);
      chk("R7 idle result", result, 128'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule